// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block derives a slower clock from a fast reference, nominally 250 MHz. Either of two timing sources paces the division. Each source arrives as a single-cycle tick qualifier in the reference domain, and a select bit picks which one the divider counts. A divisor of N therefore produces one output period for every N ticks of the chosen source. For example, with a source that ticks every cycle, N = 10 gives 25 MHz.

Software drives the block through one 16-bit configuration word. The word holds an enable, the source select, a pad speed flag and the 8-bit divisor. The output runs only when the enable is set and the divisor is 2 or more. Divisors 0 and 1 park the output low. A changed divisor, source or enable does not reach the counter until the running period has finished, so the output never shows a shortened high or low phase.

Top module: `clkdiv_gen`

## Requirements
- R1: After reset the configuration word reads 0x800A (enable set, source A, divisor 10), and the output runs with 5 ticks high and 5 ticks low.
- R2: The word decodes as bit 15 enable, bit 14 source select, bit 13 pad speed flag, and bits 7:0 divisor. Bits 12:8 read as 0 and are not changed by any write.
- R3: For an even divisor N of at least 2, each period is high for N/2 ticks and then low for N/2 ticks.
- R4: For an odd divisor N of at least 3, each period is high for (N+1)/2 ticks and then low for (N-1)/2 ticks.
- R5: The counter advances only on ticks of the selected source. Select 0 uses src_a_tick_i and select 1 uses src_b_tick_i.
- R6: A divisor of 0 or 1 holds the output low once the current period has ended. The stored divisor still reads back as written.
- R7: Clearing the enable holds the output low once the current period has ended. Setting it again restarts the output with a high phase.
- R8: A new divisor, source or enable takes effect only at a period boundary. The period in progress completes with the old settings.
- R9: The pad speed flag is readable and writable and does not change the output waveform.
- R10: Every rising edge of the output marks the start of a period, with the internal counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_a_tick_i | input | 1 | Tick qualifier of source A (select 0) |
| src_b_tick_i | input | 1 | Tick qualifier of source B (select 1) |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Configuration read data |
| div_clk_o | output | 1 | Divided clock output, registered |

## Verification
Several properties are checked on every cycle. The reserved bits always read zero. The running state never coexists with a divisor below 2. The output stays low whenever the divider is idle. The counter stays inside the active divisor. The active divisor changes only with the counter at zero, and every rising edge of the output lands on a zero count. The directed scenarios cover what needs intent and timing to show: the exact high and low lengths for even, odd, minimum and maximum divisors, doubled lengths under the slower source, completion of the old period across a reconfiguration, parking on invalid or disabled settings, and the pad speed flag having no effect.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int REG_W   = 16;
  localparam int DIV_W   = 8;
  localparam int NUM_SRC = 2;
  localparam int SEL_W   = $clog2(NUM_SRC);

  localparam int EN_BIT  = 15;
  localparam int SEL_BIT = 14;
  localparam int SPD_BIT = 13;

  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(10);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  localparam logic [REG_W-1:0] WR_MASK =
      (REG_W'(1) << EN_BIT) | (REG_W'(1) << SEL_BIT) |
      (REG_W'(1) << SPD_BIT) | REG_W'({DIV_W{1'b1}});
  localparam logic [REG_W-1:0] REG_RST = (REG_W'(1) << EN_BIT) | REG_W'(DIV_RST);

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
    logic             spd;
    logic [DIV_W-1:0] div;
  } cfg_t;
endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
  import clkdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output cfg_t             cfg_o,
  output logic [REG_W-1:0] rdata_o
);
  logic [REG_W-1:0] reg_q;

  // reserved bits are masked off on write and therefore read as zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   reg_q <= REG_RST;
    else if (we_i) reg_q <= wdata_i & WR_MASK;
  end

  always_comb begin
    cfg_o.en  = reg_q[EN_BIT];
    cfg_o.sel = reg_q[SEL_BIT -: SEL_W];
    cfg_o.spd = reg_q[SPD_BIT];
    cfg_o.div = reg_q[DIV_W-1:0];
  end

  assign rdata_o = reg_q;
endmodule

// File: rtl/clkdiv_src_mux.sv
module clkdiv_src_mux #(
  parameter int NUM_SRC = 2,
  parameter int SEL_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] ticks_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               tick_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = ticks_i[g] && (sel_i == SEL_W'(g));
  end

  assign tick_o = |hit;
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cfg_en_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic [DIV_W-1:0] div_min_i,
  output logic [SEL_W-1:0] act_sel_o,
  output logic             act_run_o,
  output logic [DIV_W-1:0] act_div_o,
  output logic [DIV_W-1:0] cnt_o,
  output logic             clk_o
);
  logic             run_q, run_n;
  logic [SEL_W-1:0] sel_q, sel_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [DIV_W:0]   hi_n;
  logic             out_q, out_n;
  logic             last, bnd;

  always_comb begin
    last  = run_q && tick_i && (cnt_q == div_q - DIV_W'(1));
    bnd   = !run_q || last;
    run_n = run_q;
    sel_n = sel_q;
    div_n = div_q;
    cnt_n = cnt_q;
    if (bnd) begin
      // settings are only taken over between periods
      run_n = cfg_en_i && (cfg_div_i >= div_min_i);
      sel_n = cfg_sel_i;
      div_n = cfg_div_i;
      cnt_n = '0;
    end else if (tick_i) begin
      cnt_n = cnt_q + DIV_W'(1);
    end
    hi_n  = ({1'b0, div_n} + (DIV_W+1)'(1)) >> 1;
    out_n = run_n && ({1'b0, cnt_n} < hi_n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      sel_q <= '0;
      div_q <= '0;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      run_q <= run_n;
      sel_q <= sel_n;
      div_q <= div_n;
      cnt_q <= cnt_n;
      out_q <= out_n;
    end
  end

  assign act_sel_o = sel_q;
  assign act_run_o = run_q;
  assign act_div_o = div_q;
  assign cnt_o     = cnt_q;
  assign clk_o     = out_q;
endmodule

// File: rtl/clkdiv_gen.sv
module clkdiv_gen
  import clkdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_a_tick_i,
  input  logic             src_b_tick_i,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  output logic             div_clk_o
);
  cfg_t             cfg;
  logic             tick;
  logic [SEL_W-1:0] act_sel;
  logic             act_run;
  logic [DIV_W-1:0] act_div;
  logic [DIV_W-1:0] act_cnt;
  logic             spd_flag;

  clkdiv_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  // pad speed flag is storage only
  assign spd_flag = cfg.spd;

  clkdiv_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .ticks_i ({src_b_tick_i, src_a_tick_i}),
    .sel_i   (act_sel),
    .tick_o  (tick)
  );

  clkdiv_core #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .cfg_en_i  (cfg.en),
    .cfg_sel_i (cfg.sel),
    .cfg_div_i (cfg.div),
    .div_min_i (DIV_MIN),
    .act_sel_o (act_sel),
    .act_run_o (act_run),
    .act_div_o (act_div),
    .cnt_o     (act_cnt),
    .clk_o     (div_clk_o)
  );
endmodule

// File: rtl/clkdiv_gen_chk.sv
module clkdiv_gen_chk
  import clkdiv_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] rdata_i,
  input logic             out_i,
  input logic             run_i,
  input logic [DIV_W-1:0] div_i,
  input logic [DIV_W-1:0] cnt_i
);
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_i & ~WR_MASK) == '0);

  a_r6_run_needs_valid_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (div_i >= DIV_MIN));

  a_r7_idle_output_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !out_i);

  a_r3_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_i < div_i));

  a_r8_div_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i != $past(div_i)) |-> (cnt_i == '0));

  a_r10_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_i) |-> (cnt_i == '0));
endmodule

bind clkdiv_gen clkdiv_gen_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rdata_i (cfg_rdata_o),
  .out_i   (div_clk_o),
  .run_i   (act_run),
  .div_i   (act_div),
  .cnt_i   (act_cnt)
);

// File: tb/clkdiv_gen_test.sv
module clkdiv_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_a = 1'b1;
  logic        src_b = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        dclk;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  clkdiv_gen uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .src_a_tick_i (src_a),
    .src_b_tick_i (src_b),
    .cfg_we_i     (we),
    .cfg_wdata_i  (wdata),
    .cfg_rdata_o  (rdata),
    .div_clk_o    (dclk)
  );

  // source B ticks every second cycle
  initial forever begin
    @(negedge clk);
    src_b = ~src_b;
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] v);
    @(negedge clk);
    we = 1'b1;
    wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_rise();
    logic p;
    p = dclk;
    forever begin
      @(negedge clk);
      if (dclk && !p) break;
      p = dclk;
    end
  endtask

  task automatic count_rest(inout int h, output int l);
    forever begin
      @(negedge clk);
      if (dclk) h++;
      else break;
    end
    l = 1;
    forever begin
      @(negedge clk);
      if (!dclk) l++;
      else break;
    end
  endtask

  task automatic measure(output int h, output int l);
    int hh;
    wait_rise();
    hh = 1;
    count_rest(hh, l);
    h = hh;
  endtask

  task automatic settle_check(string tag, int eh, int el);
    int h, l;
    measure(h, l);
    measure(h, l);
    chk({tag, " high"}, h, eh);
    chk({tag, " low"}, l, el);
  endtask

  task automatic low_for(string tag, int cycles);
    int highs = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (dclk) highs++;
    end
    chk(tag, highs, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset readback", int'(rdata), 'h800A);
    settle_check("R1 default divide", 5, 5);
  endtask

  task automatic t_reserved();
    wr(16'hFFFF);
    @(negedge clk);
    chk("R2 reserved bits read zero", int'(rdata), 'hE0FF);
    wr(16'h800A);
    @(negedge clk);
    chk("R2 plain readback", int'(rdata), 'h800A);
  endtask

  task automatic t_even();
    wr(16'h8002);
    settle_check("R3 divide 2", 1, 1);
    wr(16'h8008);
    settle_check("R3 divide 8", 4, 4);
  endtask

  task automatic t_odd();
    wr(16'h8003);
    settle_check("R4 divide 3", 2, 1);
    wr(16'h80FF);
    settle_check("R4 divide 255", 128, 127);
  endtask

  task automatic t_source();
    wr(16'hC004);
    settle_check("R5 source B divide 4", 4, 4);
    wr(16'hC003);
    settle_check("R5 source B divide 3", 4, 2);
    wr(16'h8003);
    settle_check("R5 back to source A", 2, 1);
  endtask

  task automatic t_boundary();
    int h, l;
    wr(16'h800A);
    settle_check("R8 pre", 5, 5);
    wait_rise();
    we = 1'b1;
    wdata = 16'h8006;
    @(negedge clk);
    we = 1'b0;
    h = 2;
    count_rest(h, l);
    chk("R8 old period high", h, 5);
    chk("R8 old period low", l, 5);
    h = 1;
    count_rest(h, l);
    chk("R8 new period high", h, 3);
    chk("R8 new period low", l, 3);
  endtask

  task automatic t_invalid();
    wr(16'h8001);
    repeat (20) @(negedge clk);
    low_for("R6 divide 1 parks low", 40);
    chk("R6 divide 1 readback", int'(rdata), 'h8001);
    wr(16'h8000);
    low_for("R6 divide 0 parks low", 40);
    wr(16'h8004);
    settle_check("R6 recovery", 2, 2);
  endtask

  task automatic t_disable();
    wr(16'h0006);
    repeat (12) @(negedge clk);
    low_for("R7 disabled parks low", 40);
    wr(16'h8006);
    settle_check("R7 re-enable", 3, 3);
  endtask

  task automatic t_speed();
    wr(16'hA00A);
    settle_check("R9 speed flag set", 5, 5);
    chk("R9 speed readback", int'(rdata), 'hA00A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reserved();
    t_even();
    t_odd();
    t_source();
    t_boundary();
    t_invalid();
    t_disable();
    t_speed();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule